// File: doc/BRIEF.md
# Cross-Coupled Serial Register Mailbox

The block gives two processors, a main CPU and a sound CPU, a register set each that looks like an asynchronous serial interface. The two sets are wired back to back, with no serial line between them. A byte one side transmits shows up as received data on the other side. Each side has a control register, a status register, a transmit data register and a receive data register. The main side raises `irq_o` and the sound side raises `nmi_o`.

Traffic from the sound CPU to the main CPU lands one cycle after the write. Traffic from the main CPU to the sound CPU is held back by a fixed half-millisecond delay. A down-counter times this delay, and its length comes from the clock-frequency parameter. The sound-side interrupt only reaches its pin while the external gate input `nmi_gate_i` is high.

Each side decodes one address bit. With `*_addr_i` = 0, a write loads the control register and a read returns status. With `*_addr_i` = 1, a write sends a byte and a read returns the received byte.

Top module: `acia_mailbox`

## Requirements
- R1: After rst_ni is released, both control registers hold 0x03, both status registers read 0x02, and irq_o and nmi_o are low.
- R2: The status byte is laid out as {irq, 0, overrun, 0, 0, 0, tx_empty, rx_full}. A read with address 0 returns status, and a read with address 1 returns the receive data register. Both are combinational on rdata.
- R3: A main-side write to address 1 clears the main tx_empty flag at the next edge. The byte is placed in the sound receive register and the sound rx_full flag is set exactly DELAY = CLK_HZ/2000 cycles after the write edge. Main tx_empty is set again on that same edge.
- R4: A sound-side write to address 1 loads the main receive register and sets main rx_full at the next edge. Sound tx_empty stays set.
- R5: If a byte arrives while the destination's rx_full is set, the destination's overrun flag is set. The new byte overwrites the receive register and rx_full stays set.
- R6: A read at address 1 clears that side's rx_full and overrun flags at the next edge. If a byte arrives in that same cycle, the arrival takes priority.
- R7: While control bits [1:0] are 11, the side's status flags are held at 0x02 apart from bit 7. Data writes on that side are ignored, bytes arriving there are discarded, and a pending main-to-sound transfer is cancelled and never delivered.
- R8: A side requests an interrupt when control bit 7 is set and rx_full or overrun is set. It also requests one when control bits [6:5] are 01 and tx_empty is set. The output follows the request one cycle later.
- R9: nmi_o stays low whenever nmi_gate_i was low in the previous cycle.
- R10: Status bit 7 of each side equals that side's interrupt output.
- R11: A second main-side write before delivery replaces the pending byte and restarts the full delay from the new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_wr_i | input | 1 | Main-side write strobe |
| m_rd_i | input | 1 | Main-side read strobe |
| m_addr_i | input | 1 | Main-side register select (0 control/status, 1 data) |
| m_wdata_i | input | DATA_W | Main-side write data |
| m_rdata_o | output | DATA_W | Main-side read data |
| s_wr_i | input | 1 | Sound-side write strobe |
| s_rd_i | input | 1 | Sound-side read strobe |
| s_addr_i | input | 1 | Sound-side register select (0 control/status, 1 data) |
| s_wdata_i | input | DATA_W | Sound-side write data |
| s_rdata_o | output | DATA_W | Sound-side read data |
| nmi_gate_i | input | 1 | External enable for the sound-side interrupt |
| irq_o | output | 1 | Main-side interrupt |
| nmi_o | output | 1 | Sound-side interrupt |

## Verification
The assertions check several rules on every cycle. A side held in reset must show cleared flags. Overrun may only rise on a side that was already full. An interrupt may only rise after a valid request condition. A low gate must keep nmi_o low. An accepted main-side send must clear tx_empty. Other behaviour can only be shown by the bench's scenarios: the exact delivery cycle after the long delay, the restart of that delay when a send is replaced, the cancellation of a pending send by master reset, and the byte values carried across. A cycle-level reference model in the bench follows random traffic on both sides to cover the mixes of reads, sends and control changes.

// File: rtl/acia_mbx_pkg.sv
package acia_mbx_pkg;
  localparam int unsigned ST_RXF = 0;
  localparam int unsigned ST_TXE = 1;
  localparam int unsigned ST_OVR = 5;
  localparam int unsigned ST_IRQ = 7;

  function automatic logic irq_request(input logic [7:0] ctrl, input logic rxf,
                                       input logic ovr, input logic txe);
    return (ctrl[7] && (rxf || ovr)) || ((ctrl[6:5] == 2'b01) && txe);
  endfunction
endpackage

// File: rtl/acia_delay.sv
module acia_delay #(
  parameter int unsigned CYCLES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign done_o = busy_q && (cnt_q == '0) && !start_i && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/acia_side.sv
module acia_side
  import acia_mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_i,
  input  logic              rx_rd_i,
  input  logic              arrive_i,
  input  logic [DATA_W-1:0] arrive_data_i,
  input  logic              tx_clr_i,
  input  logic              tx_set_i,
  input  logic              gate_i,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              held_o,
  output logic              irq_o
);
  logic [7:0]        ctrl_q;
  logic              rxf_q, ovr_q, txe_q, irq_q;
  logic [DATA_W-1:0] rx_q;

  assign held_o = (ctrl_q[1:0] == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 8'h03;
      rxf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      txe_q  <= 1'b1;
      irq_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_i;
      irq_q <= irq_request(ctrl_q, rxf_q, ovr_q, txe_q) && gate_i;
      if (held_o) begin
        rxf_q <= 1'b0;
        ovr_q <= 1'b0;
        txe_q <= 1'b1;
      end else begin
        if (arrive_i) begin
          ovr_q <= ovr_q | rxf_q;
          rxf_q <= 1'b1;
          rx_q  <= arrive_data_i;
        end else if (rx_rd_i) begin
          rxf_q <= 1'b0;
          ovr_q <= 1'b0;
        end
        if (tx_clr_i)      txe_q <= 1'b0;
        else if (tx_set_i) txe_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[ST_RXF] = rxf_q;
    status_o[ST_TXE] = txe_q;
    status_o[ST_OVR] = ovr_q;
    status_o[ST_IRQ] = irq_q;
  end

  assign ctrl_o    = ctrl_q;
  assign rx_data_o = rx_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/acia_mailbox.sv
module acia_mailbox #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_HZ = 125_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m_wr_i,
  input  logic              m_rd_i,
  input  logic              m_addr_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  output logic [DATA_W-1:0] m_rdata_o,
  input  logic              s_wr_i,
  input  logic              s_rd_i,
  input  logic              s_addr_i,
  input  logic [DATA_W-1:0] s_wdata_i,
  output logic [DATA_W-1:0] s_rdata_o,
  input  logic              nmi_gate_i,
  output logic              irq_o,
  output logic              nmi_o
);
  localparam int unsigned DELAY = (CLK_HZ / 2000 < 1) ? 1 : CLK_HZ / 2000;

  logic [7:0]        m_ctrl, s_ctrl, m_status, s_status;
  logic [DATA_W-1:0] m_rx, s_rx, tx_buf_q;
  logic              m_held, s_held;
  logic              m_send, s_send, m_done;

  assign m_send = m_wr_i && m_addr_i && !m_held;
  assign s_send = s_wr_i && s_addr_i && !s_held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_buf_q <= '0;
    else if (m_send) tx_buf_q <= m_wdata_i;
  end

  acia_delay #(.CYCLES(DELAY)) u_delay (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (m_send),
    .cancel_i (m_held),
    .done_o   (m_done)
  );

  acia_side #(.DATA_W(DATA_W)) u_main (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (m_wr_i && !m_addr_i),
    .ctrl_i        (m_wdata_i[7:0]),
    .rx_rd_i       (m_rd_i && m_addr_i),
    .arrive_i      (s_send),
    .arrive_data_i (s_wdata_i),
    .tx_clr_i      (m_send),
    .tx_set_i      (m_done),
    .gate_i        (1'b1),
    .ctrl_o        (m_ctrl),
    .status_o      (m_status),
    .rx_data_o     (m_rx),
    .held_o        (m_held),
    .irq_o         (irq_o)
  );

  acia_side #(.DATA_W(DATA_W)) u_sound (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_we_i     (s_wr_i && !s_addr_i),
    .ctrl_i        (s_wdata_i[7:0]),
    .rx_rd_i       (s_rd_i && s_addr_i),
    .arrive_i      (m_done),
    .arrive_data_i (tx_buf_q),
    .tx_clr_i      (1'b0),
    .tx_set_i      (1'b0),
    .gate_i        (nmi_gate_i),
    .ctrl_o        (s_ctrl),
    .status_o      (s_status),
    .rx_data_o     (s_rx),
    .held_o        (s_held),
    .irq_o         (nmi_o)
  );

  assign m_rdata_o = m_addr_i ? m_rx : DATA_W'(m_status);
  assign s_rdata_o = s_addr_i ? s_rx : DATA_W'(s_status);
endmodule

// File: rtl/acia_mailbox_chk.sv
module acia_mailbox_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_o,
  input logic       nmi_o,
  input logic       nmi_gate_i,
  input logic       m_wr_i,
  input logic       m_addr_i,
  input logic [7:0] m_ctrl,
  input logic [7:0] m_status,
  input logic [7:0] s_ctrl,
  input logic [7:0] s_status
);
  p_main_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ctrl[1:0] == 2'b11) |=> (m_status[6:0] == 7'h02));

  p_sound_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ctrl[1:0] == 2'b11) |=> (s_status[6:0] == 7'h02));

  p_ovr_needs_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(s_status[5]) |-> $past(s_status[0]));

  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((m_ctrl[7] && (m_status[0] || m_status[5])) ||
                           (m_ctrl[6:5] == 2'b01 && m_status[1])));

  p_nmi_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_gate_i |=> !nmi_o);

  p_send_clears_txe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_wr_i && m_addr_i && m_ctrl[1:0] != 2'b11) |=> !m_status[1]);
endmodule

bind acia_mailbox acia_mailbox_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .nmi_o      (nmi_o),
  .nmi_gate_i (nmi_gate_i),
  .m_wr_i     (m_wr_i),
  .m_addr_i   (m_addr_i),
  .m_ctrl     (m_ctrl),
  .m_status   (m_status),
  .s_ctrl     (s_ctrl),
  .s_status   (s_status)
);

// File: tb/tb_acia_mailbox.sv
module tb_acia_mailbox;
  localparam int unsigned HZ = 2_000_000;
  localparam int unsigned D  = HZ / 2000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic m_wr_i = 0, m_rd_i = 0, m_addr_i = 0, s_wr_i = 0, s_rd_i = 0, s_addr_i = 0;
  logic [7:0] m_wdata_i = 0, s_wdata_i = 0, m_rdata_o, s_rdata_o;
  logic nmi_gate_i = 1'b1, irq_o, nmi_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  acia_mailbox #(.DATA_W(8), .CLK_HZ(HZ)) dut (.*);

  // reference model state
  logic [7:0] mc = 8'h03, sc = 8'h03, mrx = 0, srx = 0, tbuf = 0;
  logic mrf = 0, mov = 0, mte = 1, mirq = 0, srf = 0, sov = 0, ste = 1, sirq = 0, pend = 0;
  int cnt = 0;

  function automatic logic req(input logic [7:0] c, input logic rf, ov, te);
    return (c[7] && (rf || ov)) || (c[6:5] == 2'b01 && te);
  endfunction

  function automatic logic [7:0] stat(input logic ir, ov, te, rf);
    return {ir, 1'b0, ov, 3'b000, te, rf};
  endfunction

  task automatic model_step();
    logic mh, sh, mstart, done, ssend;
    logic [7:0] n_mc, n_sc;
    mh = (mc[1:0] == 2'b11); sh = (sc[1:0] == 2'b11);
    mstart = m_wr_i && m_addr_i && !mh;
    done = pend && cnt == 0 && !mstart && !mh;
    ssend = s_wr_i && s_addr_i && !sh;
    n_mc = (m_wr_i && !m_addr_i) ? m_wdata_i : mc;
    n_sc = (s_wr_i && !s_addr_i) ? s_wdata_i : sc;
    mirq = req(mc, mrf, mov, mte);
    sirq = req(sc, srf, sov, ste) && nmi_gate_i;
    if (mh) begin mrf = 0; mov = 0; mte = 1; end
    else begin
      if (ssend) begin mov = mov | mrf; mrf = 1; mrx = s_wdata_i; end
      else if (m_rd_i && m_addr_i) begin mrf = 0; mov = 0; end
      if (mstart) mte = 0; else if (done) mte = 1;
    end
    if (sh) begin srf = 0; sov = 0; ste = 1; end
    else if (done) begin sov = sov | srf; srf = 1; srx = tbuf; end
    else if (s_rd_i && s_addr_i) begin srf = 0; sov = 0; end
    if (mh) pend = 0;
    else if (mstart) begin pend = 1; cnt = D - 1; end
    else if (pend) begin if (cnt == 0) pend = 0; else cnt--; end
    if (mstart) tbuf = m_wdata_i;
    mc = n_mc; sc = n_sc;
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    m_wr_i = 0; m_rd_i = 0; s_wr_i = 0; s_rd_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string tag, input logic [7:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic peek_m(input logic a, output logic [7:0] v);
    m_addr_i = a; #1; v = m_rdata_o;
  endtask
  task automatic peek_s(input logic a, output logic [7:0] v);
    s_addr_i = a; #1; v = s_rdata_o;
  endtask

  task automatic mwrite(input logic a, input logic [7:0] d);
    m_wr_i = 1; m_addr_i = a; m_wdata_i = d; tick();
  endtask
  task automatic swrite(input logic a, input logic [7:0] d);
    s_wr_i = 1; s_addr_i = a; s_wdata_i = d; tick();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    #20; @(negedge clk_i); rst_ni = 1;
    // R1 / R2 reset state
    peek_m(0, v); chk("R1 main status", v, 8'h02);
    peek_s(0, v); chk("R1 sound status", v, 8'h02);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
    chk("R1 nmi", {7'd0, nmi_o}, 8'h00);
    mwrite(0, 8'h00); swrite(0, 8'h00);
    // R3 delayed main->sound transfer
    mwrite(1, 8'h5A);
    peek_m(0, v); chk("R3 txe cleared", v, 8'h00);
    ticks(D - 1);
    peek_s(0, v); chk("R3 not yet delivered", v, 8'h02);
    tick();
    peek_s(0, v); chk("R3 sound rx_full", v, 8'h03);
    peek_s(1, v); chk("R3 sound data", v, 8'h5A);
    peek_m(0, v); chk("R3 main txe back", v, 8'h02);
    // R6 read clears
    s_rd_i = 1; s_addr_i = 1; tick();
    peek_s(0, v); chk("R6 sound cleared", v, 8'h02);
    // R4 sound->main
    swrite(1, 8'hC3);
    peek_m(0, v); chk("R4 main rx_full", v, 8'h03);
    peek_m(1, v); chk("R4 main data", v, 8'hC3);
    peek_s(0, v); chk("R4 sound txe kept", v, 8'h02);
    // R5 overrun
    swrite(1, 8'h11);
    peek_m(0, v); chk("R5 overrun", v, 8'h23);
    peek_m(1, v); chk("R5 overwrite", v, 8'h11);
    // R8 / R10 receive interrupt
    mwrite(0, 8'h80); tick();
    chk("R8 irq on rx", {7'd0, irq_o}, 8'h01);
    peek_m(0, v); chk("R10 status bit7", v, 8'hA3);
    m_rd_i = 1; m_addr_i = 1; tick();
    peek_m(0, v); chk("R6 main cleared", v, 8'h82);
    tick();
    chk("R8 irq released", {7'd0, irq_o}, 8'h00);
    // R8 transmit-empty interrupt
    mwrite(0, 8'h20); tick();
    chk("R8 irq on txe", {7'd0, irq_o}, 8'h01);
    mwrite(0, 8'h00); tick();
    // R9 gate
    nmi_gate_i = 0; swrite(0, 8'h20); ticks(3);
    chk("R9 nmi gated", {7'd0, nmi_o}, 8'h00);
    nmi_gate_i = 1; tick();
    chk("R9 nmi passes", {7'd0, nmi_o}, 8'h01);
    peek_s(0, v); chk("R10 sound bit7", v, 8'h82);
    swrite(0, 8'h00);
    // R7 master reset cancels pending
    mwrite(1, 8'h77); ticks(10);
    mwrite(0, 8'h03);
    mwrite(1, 8'h99);
    peek_m(0, v); chk("R7 held status", v, 8'h02);
    ticks(D + 5);
    peek_s(0, v); chk("R7 no delivery", v, 8'h02);
    mwrite(0, 8'h00);
    // R11 replace pending byte
    mwrite(1, 8'h11); ticks(500);
    mwrite(1, 8'h22); ticks(D - 1);
    peek_s(0, v); chk("R11 restart not early", v, 8'h02);
    tick();
    peek_s(1, v); chk("R11 replaced byte", v, 8'h22);
    s_rd_i = 1; s_addr_i = 1; tick();
    // random phase against reference model
    for (int n = 0; n < 20000; n++) begin
      logic [7:0] r;
      if ($urandom % 50 == 0) begin
        r = 8'($urandom);
        if (r[1:0] == 2'b11 && $urandom % 8 != 0) r[1:0] = 2'b00;
        m_wr_i = 1; m_addr_i = 0; m_wdata_i = r;
      end else if ($urandom % 1500 == 0) begin
        m_wr_i = 1; m_addr_i = 1; m_wdata_i = 8'($urandom);
      end else begin
        m_rd_i = ($urandom % 20 == 0); m_addr_i = 1'($urandom);
      end
      if ($urandom % 50 == 0) begin
        r = 8'($urandom);
        if (r[1:0] == 2'b11 && $urandom % 8 != 0) r[1:0] = 2'b00;
        s_wr_i = 1; s_addr_i = 0; s_wdata_i = r;
      end else if ($urandom % 40 == 0) begin
        s_wr_i = 1; s_addr_i = 1; s_wdata_i = 8'($urandom);
      end else begin
        s_rd_i = ($urandom % 20 == 0); s_addr_i = 1'($urandom);
      end
      if ($urandom % 100 == 0) nmi_gate_i = ~nmi_gate_i;
      #1;
      chk("R2 main rdata model", m_rdata_o, m_addr_i ? mrx : stat(mirq, mov, mte, mrf));
      chk("R2 sound rdata model", s_rdata_o, s_addr_i ? srx : stat(sirq, sov, ste, srf));
      tick();
      chk("R8 irq model", {7'd0, irq_o}, {7'd0, mirq});
      chk("R9 nmi model", {7'd0, nmi_o}, {7'd0, sirq});
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule